// File: doc/BRIEF.md
# EEPROM Byte Access Controller

This block gives a host single-byte access to a nonvolatile byte array through two 32-bit registers. The command register holds a byte address, a two-bit operation code, a busy flag and a sticky timeout flag. The data register holds the byte to be stored, or the byte most recently fetched. To start an access, the host writes the command word with the busy bit set. The controller performs the access and then clears busy by itself. If the storage device does not answer within a fixed number of cycles, the controller raises the timeout flag instead.

The storage device is a behavioural byte array inside the block. Two inputs make it configurable: one gives its answer latency in cycles, and one says whether a device is present at all. A host driver writes the data byte first. It then writes the command word once without busy, which also clears any old timeout, and writes it again with busy set. It then polls busy. To detect a device, the host clears the timeout flag and issues a busy-only command. A timeout afterwards means no device is present.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, busy, timeout, the operation code, the address and the data byte are all zero, so both registers read as zero.
- R2: The command register is at offset 0x00 and reads back as follows: busy in bit 31, the operation code in bits 29:28, timeout in bit 17 and the address in bits 12:0, with every other bit zero. The data register is at offset 0x04 and reads its byte in bits 7:0, with bits 31:8 zero.
- R3: A write to offset 0x00 while idle latches the operation code and the address. It sets busy only if bit 31 of the written word is 1. A word with bit 31 clear updates the fields and starts nothing.
- R4: With a device present and a latency L no greater than TIMEOUT_CYC (default 64), busy reads 1 for exactly L+1 clock cycles after the starting write, and timeout stays 0.
- R5: Operation code 11 is a write. When it completes, the low byte of the data register is stored at the command address.
- R6: Any other operation code, such as 00, is a read. When busy clears, the data register holds the byte stored at the command address.
- R7: If the device is absent, or L is greater than TIMEOUT_CYC, busy reads 1 for TIMEOUT_CYC+1 cycles, then clears with timeout set. Neither the array nor the data register changes.
- R8: The timeout flag is sticky. It is cleared only by writing 1 to bit 17 at offset 0x00, and this clearing works even while busy is set. Writing 0 to bit 17 leaves the flag unchanged.
- R9: While busy is set, writes to offset 0x00 leave the operation code, the address and busy unchanged, and writes to offset 0x04 are ignored.
- R10: A probe consists of writing 0x0002_0000 and then 0x8000_0000 to offset 0x00. It ends with busy and timeout both clear when a device is present, and with timeout set when no device is present.
- R11: The array holds 2^MEM_AW bytes (default 2048). Command address bits at and above bit MEM_AW alias onto the same byte.
- R12: Writes to offsets other than 0x00 and 0x04 have no effect, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| dev_present | input | 1 | High when the storage device answers |
| dev_latency | input | LAT_W | Cycles the device takes to answer |

## Verification
Random sequences of byte writes and reads run with random addresses, random data, latencies on both sides of the limit, and an occasionally absent device. This separates three cases: an access that completes, an access that times out because the device is slow, and an access that times out because the device is missing. The check compares both the number of busy cycles and the contents of the array. Directed cases cover the following. The latencies 0, TIMEOUT_CYC and TIMEOUT_CYC+1 show where the boundary between completion and timeout lies. Addresses that differ only above bit MEM_AW show the aliasing. Command and data writes during busy show that they are ignored, while a timeout clear in the same window still takes effect. Finally, the probe sequence runs with and without a device.

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int MEM_AW      = 11,
  parameter int LAT_W       = 8,
  parameter int TIMEOUT_CYC = 64,
  parameter int REG_AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dev_present,
  input  logic [LAT_W-1:0]  dev_latency
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 2);
  localparam int DEPTH = 2 ** MEM_AW;
  localparam logic [REG_AW-1:0] OFS_CMD  = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_DATA = REG_AW'(4);
  localparam logic [1:0] OP_WRITE = 2'b11;

  logic              busy_q, tout_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        mem [DEPTH];

  wire cmd_wr  = bus_we && (bus_addr == OFS_CMD);
  wire data_wr = bus_we && (bus_addr == OFS_DATA);
  wire ok_now  = busy_q && dev_present && (32'(cnt_q) == 32'(dev_latency));
  wire to_now  = busy_q && !ok_now && (32'(cnt_q) == 32'(TIMEOUT_CYC));
  wire is_wr   = (op_q == OP_WRITE);
  wire [MEM_AW-1:0] mem_idx = addr_q[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tout_q <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (ok_now || to_now) busy_q <= 1'b0;
        if (ok_now && !is_wr) data_q <= mem[mem_idx];
      end else begin
        if (cmd_wr) begin
          busy_q <= bus_wdata[31];
          op_q   <= bus_wdata[29:28];
          addr_q <= bus_wdata[ADDR_W-1:0];
          cnt_q  <= '0;
        end
        if (data_wr) data_q <= bus_wdata[7:0];
      end
      if (to_now) tout_q <= 1'b1;
      else if (cmd_wr && bus_wdata[17]) tout_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ok_now && is_wr) mem[mem_idx] <= data_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CMD) begin
      bus_rdata[31]         = busy_q;
      bus_rdata[29:28]      = op_q;
      bus_rdata[17]         = tout_q;
      bus_rdata[ADDR_W-1:0] = addr_q;
    end else if (bus_addr == OFS_DATA) begin
      bus_rdata[7:0] = data_q;
    end
  end

  p_busy_needs_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(cmd_wr && bus_wdata[31])) |=> !busy_q);

  p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(op_q) && $stable(data_q)));

  p_tout_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_q) |-> $fell(busy_q));

  p_success_needs_device_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$rose(tout_q)) |-> $past(dev_present));

  p_tout_clear_by_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tout_q) |-> $past(cmd_wr && bus_wdata[17]));
endmodule

// File: tb/eeprom_cmd_ctrl_tb.sv
module eeprom_cmd_ctrl_tb;
  localparam int T = 64;
  localparam int MAW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dev_present = 1'b1;
  logic [7:0]  dev_latency = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  model [2**MAW];
  logic [12:0] wlist [64];
  int          wcnt = 0;
  logic [7:0]  exp_data = '0;

  eeprom_cmd_ctrl #(.ADDR_W(13), .MEM_AW(MAW), .LAT_W(8), .TIMEOUT_CYC(T), .REG_AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_present(dev_present), .dev_latency(dev_latency));

  always #10 clk = ~clk;

  function automatic logic [31:0] cmd_word(bit busy, logic [1:0] op, bit tout, logic [12:0] a);
    return {busy, 1'b0, op, 10'b0, tout, 4'b0, a};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      @(negedge clk);
      bus_addr = 8'h00;
      #1 v = bus_rdata;
      if (!v[31]) break;
      n++;
      if (n > 1000) break;
    end
  endtask

  task automatic do_write(logic [12:0] a, logic [7:0] b, int lat, bit pres);
    int n; logic [31:0] v; bit ok;
    ok = pres && (lat <= T);
    dev_latency = 8'(lat); dev_present = pres;
    wr(8'h04, {24'hABCDEF, b});
    wr(8'h00, cmd_word(1'b0, 2'b11, 1'b1, a));
    wr(8'h00, cmd_word(1'b1, 2'b11, 1'b0, a));
    wait_idle(n);
    chk(n == (ok ? lat + 1 : T + 1), ok ? "R4 write busy cycles" : "R7 write timeout cycles", n, ok ? lat + 1 : T + 1);
    exp_data = b;
    if (ok) begin
      model[a[MAW-1:0]] = b;
      if (wcnt < 64) begin wlist[wcnt] = a; wcnt++; end
    end
    rd(8'h00, v);
    chk(v == cmd_word(1'b0, 2'b11, !ok, a), "R5 command readback after write", v, cmd_word(1'b0, 2'b11, !ok, a));
  endtask

  task automatic do_read(logic [12:0] a, int lat, bit pres);
    int n; logic [31:0] v; bit ok;
    ok = pres && (lat <= T);
    dev_latency = 8'(lat); dev_present = pres;
    wr(8'h00, cmd_word(1'b0, 2'b00, 1'b1, a));
    wr(8'h00, cmd_word(1'b1, 2'b00, 1'b0, a));
    wait_idle(n);
    chk(n == (ok ? lat + 1 : T + 1), ok ? "R4 read busy cycles" : "R7 read timeout cycles", n, ok ? lat + 1 : T + 1);
    if (ok) exp_data = model[a[MAW-1:0]];
    rd(8'h04, v);
    chk(v == {24'b0, exp_data}, ok ? "R6 read data" : "R7 data unchanged on timeout", v, {24'b0, exp_data});
    rd(8'h00, v);
    chk(v[17] == !ok, "R7 timeout flag", v, cmd_word(1'b0, 2'b00, !ok, a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h00, v); chk(v == 32'h0, "R1 command reset", v, 32'h0);
    rd(8'h04, v); chk(v == 32'h0, "R1 data reset", v, 32'h0);

    wr(8'h00, 32'h3400_BABC);
    rd(8'h00, v); chk(v == cmd_word(1'b0, 2'b11, 1'b0, 13'h1ABC), "R2 R3 field layout without start", v, 32'h3000_1ABC);
    wr(8'h04, 32'hFFFF_FF5A);
    rd(8'h04, v); chk(v == 32'h5A, "R2 data register width", v, 32'h5A);

    wr(8'h08, 32'hB000_0001);
    rd(8'h00, v); chk(v[31] == 1'b0, "R12 other offset no start", v, 32'h3000_1ABC);
    rd(8'h08, v); chk(v == 32'h0, "R12 other offset reads zero", v, 32'h0);

    do_write(13'h0000, 8'h11, 0, 1'b1);
    do_write(13'h0123, 8'hC3, T, 1'b1);
    do_write(13'h0124, 8'h77, T + 1, 1'b1);
    do_read(13'h0124, 3, 1'b1);
    do_read(13'h0123, 0, 1'b1);

    do_write(13'h0005, 8'h9E, 7, 1'b1);
    do_read(13'h0805, 2, 1'b1);
    chk(exp_data == 8'h9E, "R11 alias read", exp_data, 8'h9E);

    for (int i = 0; i < 60; i++) begin
      int lat; bit pres;
      lat = $urandom_range(0, 80);
      pres = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 1) == 0 || wcnt == 0)
        do_write(13'($urandom_range(0, 8191)), 8'($urandom_range(0, 255)), lat, pres);
      else
        do_read(wlist[$urandom_range(0, wcnt - 1)], lat, pres);
    end

    do_read(13'h0005, 1, 1'b0);
    wr(8'h00, 32'h0000_0010);
    rd(8'h00, v); chk(v[17] == 1'b1, "R8 sticky without clear", v, 32'h0002_0010);

    dev_present = 1'b1; dev_latency = 8'd20;
    wr(8'h00, cmd_word(1'b1, 2'b00, 1'b0, 13'h0123));
    rd(8'h00, v); chk(v == cmd_word(1'b1, 2'b00, 1'b1, 13'h0123), "R8 flag kept during busy", v, cmd_word(1'b1, 2'b00, 1'b1, 13'h0123));
    wr(8'h00, cmd_word(1'b1, 2'b11, 1'b1, 13'h0AAA));
    wr(8'h04, 32'h0000_00EE);
    rd(8'h00, v); chk(v == cmd_word(1'b1, 2'b00, 1'b0, 13'h0123), "R9 R8 busy write ignored but clear taken", v, cmd_word(1'b1, 2'b00, 1'b0, 13'h0123));
    wait_idle(n);
    rd(8'h04, v); chk(v == {24'b0, model[11'h123]}, "R9 data write ignored while busy", v, {24'b0, model[11'h123]});

    dev_present = 1'b1; dev_latency = 8'd5;
    wr(8'h00, 32'h0002_0000);
    wr(8'h00, 32'h8000_0000);
    wait_idle(n);
    rd(8'h00, v); chk(v[31] == 1'b0 && v[17] == 1'b0, "R10 probe with device", v, 32'h0);
    dev_present = 1'b0;
    wr(8'h00, 32'h0002_0000);
    wr(8'h00, 32'h8000_0000);
    wait_idle(n);
    rd(8'h00, v); chk(v[31] == 1'b0 && v[17] == 1'b1, "R10 probe without device", v, 32'h0002_0000);

    finish_run();
  end
endmodule